// File: doc/BRIEF.md
# Funnel Shift Unit

The funnel shift unit joins two 32-bit operands into one 64-bit word, with the high operand in bits 63:32 and the low operand in bits 31:0. It shifts that word left or right by a variable count and returns one 32-bit half. A left shift returns the upper half and a right shift returns the lower half. Callers use it for shifts across several words, for realigning data that straddles a word boundary, and for rotates. A rotate is obtained by presenting the same value on both operands.

Two policies turn the 32-bit unsigned count into the amount actually shifted. The wrap policy keeps the five low bits, which gives 0..31. The clamp policy saturates the count to 0..32, so a count of 32 or more hands back one whole operand. Vacated positions inside the 64-bit word fill with zeros, but that fill never reaches the returned half. An optional output register, on by default, adds one cycle of latency. A valid flag tracks the input strobe, and there is no backpressure.

Top module: `funnel_shift_unit`

## Requirements
- R1: With the direction select low (left) and the count-mode select low (wrap), the result is bits 63:32 of ({hi,lo} << n), where n = amount mod 32.
- R2: With the direction select high (right) and wrap mode, the result is bits 31:0 of ({hi,lo} >> n), where n = amount mod 32. In particular, a count whose low five bits are zero returns lo.
- R3: In wrap mode, bits 31:5 of the amount have no effect. For example, an amount of 32, 64 or 0xFFFFFFE0 gives the same result as 0.
- R4: With the count-mode select high (clamp), any unsigned amount of 32 or more, up to 0xFFFFFFFF, acts as 32. A left shift then returns lo and a right shift returns hi.
- R5: In clamp mode, amounts 0..31 give the same result as wrap mode.
- R6: When hi equals lo, the result is hi rotated by the effective count in the selected direction, and so it keeps the operand's population count.
- R7: In the registered configuration, out_valid equals in_valid of the previous clock cycle. The result for an accepted input appears one cycle after the edge that accepts it. Reset drives out_valid and the result to 0.
- R8: In the registered configuration, a cycle with in_valid low leaves the result unchanged, whatever the other inputs do.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are presented this cycle |
| hi | input | 32 | Operand placed in bits 63:32 |
| lo | input | 32 | Operand placed in bits 31:0 |
| amount | input | 32 | Unsigned shift count |
| dir_right | input | 1 | 0 = left (upper half out), 1 = right (lower half out) |
| clamp_mode | input | 1 | 0 = wrap count to 5 bits, 1 = saturate count at 32 |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Selected 32-bit half of the shifted word |

## Verification
Every result is due exactly one clock edge after the edge that captured its inputs. The bench drives operands on a falling edge and lets the next rising edge capture them. It compares result and out_valid on the falling edge that follows, so every comparison sits half a period away from any register update. Hold behaviour is checked the same way: after an idle cycle with disturbed inputs, the bench reads the outputs on the next falling edge. The checker's temporal properties use a one-cycle $past window that matches this latency.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned AMT_W  = 32;

    typedef enum logic {
        SHIFT_LEFT  = 1'b0,
        SHIFT_RIGHT = 1'b1
    } shift_dir_e;

    typedef enum logic {
        CNT_WRAP  = 1'b0,
        CNT_CLAMP = 1'b1
    } cnt_mode_e;
endpackage

// File: rtl/fsu_count.sv
// Turns the raw unsigned shift amount into the effective count.
module fsu_count #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 32,
    localparam int unsigned CW = $clog2(W) + 1
) (
    input  logic [AW-1:0]       amount,
    input  fsu_pkg::cnt_mode_e  mode,
    output logic [CW-1:0]       count
);
    localparam logic [AW-1:0] SAT_LIMIT = AW'(W);

    always_comb begin
        if (mode == fsu_pkg::CNT_CLAMP) begin
            // saturate at one full word
            if (amount >= SAT_LIMIT) count = CW'(W);
            else                     count = amount[CW-1:0];
        end else begin
            // keep only log2(W) bits: 0..W-1
            count = {1'b0, amount[CW-2:0]};
        end
    end
endmodule

// File: rtl/fsu_core.sv
// Concatenates the operands, shifts the double word and picks one half.
module fsu_core #(
    parameter int unsigned W  = 32,
    localparam int unsigned CW = $clog2(W) + 1,
    localparam int unsigned DW = 2 * W
) (
    input  logic [W-1:0]        hi,
    input  logic [W-1:0]        lo,
    input  logic [CW-1:0]       count,
    input  fsu_pkg::shift_dir_e dir,
    output logic [W-1:0]        half
);
    logic [DW-1:0] joined;
    logic [DW-1:0] shl;
    logic [DW-1:0] shr;

    always_comb begin
        joined = {hi, lo};
        shl    = joined << count;
        shr    = joined >> count;
        if (dir == fsu_pkg::SHIFT_RIGHT) half = shr[W-1:0];
        else                             half = shl[DW-1:W];
    end
endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit #(
    parameter int unsigned W       = fsu_pkg::WORD_W,
    parameter int unsigned AW      = fsu_pkg::AMT_W,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned CW     = $clog2(W) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  hi,
    input  logic [W-1:0]  lo,
    input  logic [AW-1:0] amount,
    input  logic          dir_right,
    input  logic          clamp_mode,
    output logic          out_valid,
    output logic [W-1:0]  result
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
    } stage_t;

    fsu_pkg::shift_dir_e dir_sel;
    fsu_pkg::cnt_mode_e  mode_sel;
    logic [CW-1:0]       eff_count;
    logic [W-1:0]        half_out;

    assign dir_sel  = fsu_pkg::shift_dir_e'(dir_right);
    assign mode_sel = fsu_pkg::cnt_mode_e'(clamp_mode);

    fsu_count #(.W(W), .AW(AW)) u_count (
        .amount (amount),
        .mode   (mode_sel),
        .count  (eff_count)
    );

    fsu_core #(.W(W)) u_core (
        .hi    (hi),
        .lo    (lo),
        .count (eff_count),
        .dir   (dir_sel),
        .half  (half_out)
    );

    generate
        if (REG_OUT) begin : g_reg
            stage_t stage_d, stage_q;

            always_comb begin
                stage_d     = stage_q;
                stage_d.vld = in_valid;
                if (in_valid) stage_d.res = half_out;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= stage_d;
            end

            assign out_valid = stage_q.vld;
            assign result    = stage_q.res;
        end else begin : g_comb
            assign out_valid = in_valid;
            assign result    = half_out;
        end
    endgenerate
endmodule

// File: rtl/fsu_checker.sv
module fsu_checker #(
    parameter int unsigned W       = 32,
    parameter int unsigned AW      = 32,
    parameter bit          REG_OUT = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [W-1:0]  hi,
    input logic [W-1:0]  lo,
    input logic [AW-1:0] amount,
    input logic          dir_right,
    input logic          clamp_mode,
    input logic          out_valid,
    input logic [W-1:0]  result
);
    localparam logic [AW-1:0] LIM = AW'(W);
    localparam int unsigned   LB  = $clog2(W);

    generate
        if (REG_OUT) begin : g_chk
            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == $past(in_valid)); // R7
            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(result)); // R8
            AST_CLAMP_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && clamp_mode && !dir_right && amount >= LIM) |=> result == $past(lo)); // R4
            AST_CLAMP_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && clamp_mode && dir_right && amount >= LIM) |=> result == $past(hi)); // R4
            AST_WRAP_ZERO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !clamp_mode && !dir_right && amount[LB-1:0] == '0) |=> result == $past(hi)); // R3
            AST_WRAP_ZERO_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !clamp_mode && dir_right && amount[LB-1:0] == '0) |=> result == $past(lo)); // R2
            AST_ROTATE_POP: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && hi == lo) |=> $countones(result) == $countones($past(hi))); // R6
        end
    endgenerate
endmodule

bind funnel_shift_unit fsu_checker #(.W(W), .AW(AW), .REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .hi         (hi),
    .lo         (lo),
    .amount     (amount),
    .dir_right  (dir_right),
    .clamp_mode (clamp_mode),
    .out_valid  (out_valid),
    .result     (result)
);

// File: tb/sim_funnel_shift_unit.sv
`timescale 1ns/1ps
module sim_funnel_shift_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] hi = '0, lo = '0, amount = '0;
    logic        dir_right = 1'b0, clamp_mode = 1'b0;
    logic        out_valid;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    funnel_shift_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .hi(hi), .lo(lo), .amount(amount),
        .dir_right(dir_right), .clamp_mode(clamp_mode),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] model(input logic [31:0] h, input logic [31:0] l,
                                          input logic [31:0] a, input logic r, input logic c);
        logic [63:0] w;
        int unsigned n;
        if (c) n = (a >= 32) ? 32 : a;
        else   n = a % 32;
        w = {h, l};
        if (r) model = 32'(w >> n);
        else   model = 32'((w << n) >> 32);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] h, input logic [31:0] l, input logic [31:0] a,
                         input logic r, input logic c);
        string tag;
        logic [31:0] exp;
        @(negedge clk);
        in_valid = 1'b1; hi = h; lo = l; amount = a; dir_right = r; clamp_mode = c;
        exp = model(h, l, a, r, c);
        if (h == l)               tag = "R6";
        else if (c && a >= 32)    tag = "R4";
        else if (c)               tag = "R5";
        else if (a >= 32)         tag = "R3";
        else if (r)               tag = "R2";
        else                      tag = "R1";
        @(negedge clk);
        check(tag, result, exp);
        check("R7 valid", {31'd0, out_valid}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        logic [31:0] pats_hi [4];
        logic [31:0] pats_lo [4];
        pats_hi[0] = 32'hA5A5_0F0F; pats_lo[0] = 32'h1234_5678;
        pats_hi[1] = 32'hFFFF_FFFF; pats_lo[1] = 32'h0000_0000;
        pats_hi[2] = 32'h0000_0000; pats_lo[2] = 32'hFFFF_FFFF;
        pats_hi[3] = 32'h8000_0013; pats_lo[3] = 32'h8000_0013;

        #1;
        check("R7 reset valid", {31'd0, out_valid}, 32'd0);
        check("R7 reset result", result, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle valid", {31'd0, out_valid}, 32'd0);

        // counts 0..40, both modes, both directions, several patterns
        for (int p = 0; p < 4; p++)
            for (int m = 0; m < 2; m++)
                for (int d = 0; d < 2; d++)
                    for (int a = 0; a <= 40; a++)
                        apply(pats_hi[p], pats_lo[p], 32'(a), d[0], m[0]);

        // large amounts: high bits ignored in wrap (R3), saturate in clamp (R4)
        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 2; d++) begin
                apply(32'hDEAD_BEEF, 32'h0BAD_F00D, 32'hFFFF_FFFF, d[0], m[0]);
                apply(32'hDEAD_BEEF, 32'h0BAD_F00D, 32'hFFFF_FFE0, d[0], m[0]);
                apply(32'hDEAD_BEEF, 32'h0BAD_F00D, 32'd64,        d[0], m[0]);
                apply(32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h8000_0003, d[0], m[0]);
            end

        // explicit rotate: R6
        apply(32'h8000_0001, 32'h8000_0001, 32'd1, 1'b0, 1'b0);
        check("R6 rotl1", result, 32'h0000_0003);
        apply(32'h8000_0001, 32'h8000_0001, 32'd1, 1'b1, 1'b0);
        check("R6 rotr1", result, 32'hC000_0000);

        // idle cycle with disturbed inputs: R8 hold, R7 valid drops
        held = result;
        @(negedge clk);
        in_valid = 1'b0; hi = 32'h1111_2222; lo = 32'h3333_4444; amount = 32'd7;
        dir_right = 1'b1; clamp_mode = 1'b1;
        @(negedge clk);
        check("R8 hold", result, held);
        check("R7 valid low", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check("R8 hold 2", result, held);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule